// File: doc/BRIEF.md
# Three-Digit Carry-Select BCD Adder

This block adds two packed decimal operands of three digits each (0 to 999) and returns a three-digit packed decimal sum together with a decimal carry-out. It works on the decimal digits directly and never converts to or from binary. It is purely combinational, so it fits inside any single-cycle datapath that already holds decimal values.

One wide binary addition produces a raw nibble and a nibble-boundary carry for every digit. In parallel with that, each digit position computes a copy of its nibble with six added. Six is the distance between radix sixteen and radix ten. A per-digit select then picks the raw nibble or the adjusted nibble. Where a lower digit generated a decimal carry that the binary add did not propagate, the next digit is incremented before its own adjust decision. The digit count is a parameter, and the default is three.

Top module: `bcd_csel_adder`

## Requirements
- R1: With every operand nibble in 0..9, `dec_sum` holds the decimal value (A + B) mod 1000. Each nibble is one digit, and bits [3:0] are the least significant digit.
- R2: `dec_cout` is 1 exactly when A + B is 1000 or more, which covers sums 1000 to 1998. Otherwise it is 0.
- R3: 568 + 379 gives sum 0x947 with carry 0.
- R4: When no digit position reaches ten, the raw binary nibbles pass through unchanged. For example, 123 + 456 gives 0x579.
- R5: A digit pair whose binary nibble sum overflows four bits, such as 9 + 9, yields digit 8 and a carry into the next digit.
- R6: A digit pair whose nibble sum falls in the skipped codes 1010..1111 without overflowing four bits, such as 5 + 5, yields digit 0 and a carry into the next digit.
- R7: A decimal carry that the binary add missed is applied as an increment to the next digit. The adjust decision for that digit uses the incremented value, so carries ripple across digits: 999 + 001 gives 000 with carry 1, and 499 + 501 gives 000 with carry 1.
- R8: The largest case, 999 + 999, gives 0x998 with carry 1.
- R9: For valid operands, every nibble of `dec_sum` is in 0..9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 12 | First operand, packed decimal, least significant digit in bits [3:0] |
| opnd_b | input | 12 | Second operand, packed decimal |
| dec_sum | output | 12 | Three-digit packed decimal sum |
| dec_cout | output | 1 | Decimal carry-out, set for sums of 1000 and above |

## Verification
The bench builds the adder with its default of three digits. At that size the whole valid input space, all one million operand pairs, can be swept in well under the cycle limit, so every combination of raw, adjusted and incremented digit selection is reached, including the rare chains where an increment pushes a digit from 9 into the skipped codes. Directed cases placed ahead of the sweep single out the worked example, the pass-through path, each carry mechanism and the extreme sums.

// File: rtl/bcd_csel_pkg.sv
package bcd_csel_pkg;

    localparam int          NIB_W     = 4;
    localparam logic [3:0]  SKIP_ADJ  = 4'd6;   // 16 - 10 unused codes
    localparam logic [3:0]  DIGIT_MAX = 4'd9;

    typedef logic [NIB_W-1:0] nib_t;

    // Output of the binary stage for one digit position
    typedef struct packed {
        nib_t raw;      // raw binary nibble of the wide add
        logic bin_c;    // carry out of this nibble's top bit
    } bin_nib_t;

    // Final decimal digit
    typedef struct packed {
        nib_t digit;
        logic dec_c;    // decimal carry toward the next digit
    } dec_digit_t;

    function automatic logic [NIB_W:0] plus_six(input nib_t v);
        return {1'b0, v} + {1'b0, SKIP_ADJ};
    endfunction

    function automatic logic nib_is_digit(input nib_t v);
        return v <= DIGIT_MAX;
    endfunction

endpackage

// File: rtl/bcd_bin_stage.sv
module bcd_bin_stage
    import bcd_csel_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic [DIGITS*NIB_W-1:0] a_i,
    input  logic [DIGITS*NIB_W-1:0] b_i,
    output bin_nib_t [DIGITS-1:0]   nib_o
);

    localparam int W = DIGITS * NIB_W;

    logic [W:0] full_sum;
    assign full_sum = {1'b0, a_i} + {1'b0, b_i};

    // Carry out of bit 4k+3 is recovered from a partial add of the low bits
    for (genvar k = 0; k < DIGITS; k++) begin : g_nib
        localparam int TOP = NIB_W * (k + 1);
        logic [TOP:0] part;
        assign part           = {1'b0, a_i[TOP-1:0]} + {1'b0, b_i[TOP-1:0]};
        assign nib_o[k].raw   = full_sum[TOP-1 -: NIB_W];
        assign nib_o[k].bin_c = part[TOP];
    end

endmodule

// File: rtl/bcd_digit_select.sv
module bcd_digit_select
    import bcd_csel_pkg::*;
(
    input  bin_nib_t   nib_i,
    input  logic       inc_i,   // decimal carry the binary add did not deliver
    output dec_digit_t dig_o
);

    logic [NIB_W:0] bumped;
    logic [NIB_W:0] adjusted;
    logic           take_adj;

    always_comb begin
        bumped   = {1'b0, nib_i.raw} + {{NIB_W{1'b0}}, inc_i};
        adjusted = plus_six(bumped[NIB_W-1:0]);
        take_adj = nib_i.bin_c | bumped[NIB_W] | adjusted[NIB_W];
        dig_o.digit = take_adj ? adjusted[NIB_W-1:0] : bumped[NIB_W-1:0];
        dig_o.dec_c = take_adj;
    end

endmodule

// File: rtl/bcd_csel_adder.sv
module bcd_csel_adder
    import bcd_csel_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic [DIGITS*4-1:0] opnd_a,
    input  logic [DIGITS*4-1:0] opnd_b,
    output logic [DIGITS*4-1:0] dec_sum,
    output logic                dec_cout
);

    bin_nib_t   [DIGITS-1:0] nib;
    dec_digit_t [DIGITS-1:0] dig;
    logic       [DIGITS:0]   inc;

    bcd_bin_stage #(.DIGITS(DIGITS)) u_bin (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .nib_o (nib)
    );

    assign inc[0] = 1'b0;

    for (genvar k = 0; k < DIGITS; k++) begin : g_dig
        bcd_digit_select u_sel (
            .nib_i (nib[k]),
            .inc_i (inc[k]),
            .dig_o (dig[k])
        );
        // Increment the next digit only if the binary add did not already carry
        assign inc[k+1] = dig[k].dec_c & ~nib[k].bin_c;
        assign dec_sum[NIB_W*k +: NIB_W] = dig[k].digit;
    end

    assign dec_cout = dig[DIGITS-1].dec_c;

endmodule

// File: rtl/bcd_csel_adder_chk.sv
module bcd_csel_adder_chk
    import bcd_csel_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input logic [DIGITS*4-1:0] opnd_a,
    input logic [DIGITS*4-1:0] opnd_b,
    input logic [DIGITS*4-1:0] dec_sum,
    input logic                dec_cout
);

    function automatic longint dec_val(input logic [DIGITS*4-1:0] v);
        longint acc = 0;
        for (int k = DIGITS - 1; k >= 0; k--) acc = acc * 10 + longint'(v[4*k +: 4]);
        return acc;
    endfunction

    function automatic logic all_digits(input logic [DIGITS*4-1:0] v);
        logic ok = 1'b1;
        for (int k = 0; k < DIGITS; k++) ok &= nib_is_digit(v[4*k +: 4]);
        return ok;
    endfunction

    function automatic longint modulus();
        longint m = 1;
        for (int k = 0; k < DIGITS; k++) m = m * 10;
        return m;
    endfunction

    longint total;
    logic   valid_in;

    always_comb begin
        valid_in = all_digits(opnd_a) & all_digits(opnd_b);
        total    = dec_val(opnd_a) + dec_val(opnd_b);
        if (valid_in) begin
            // R1
            sum_value_chk: assert (dec_val(dec_sum) == total % modulus())
                else $error("sum value mismatch");
            // R2
            carry_out_chk: assert (dec_cout == (total >= modulus()))
                else $error("carry-out mismatch");
            // R9
            digit_range_chk: assert (all_digits(dec_sum))
                else $error("output digit outside 0..9");
            // R8
            max_case_chk: assert (!(dec_val(opnd_a) == modulus() - 1 &&
                                    dec_val(opnd_b) == modulus() - 1) || dec_cout)
                else $error("largest sum lost its carry");
        end
    end

endmodule

bind bcd_csel_adder bcd_csel_adder_chk #(.DIGITS(DIGITS)) u_chk (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .dec_sum  (dec_sum),
    .dec_cout (dec_cout)
);

// File: tb/bcd_csel_adder_test.sv
module bcd_csel_adder_test;

    localparam int DIGITS   = 3;
    localparam int W        = DIGITS * 4;
    localparam int WATCHDOG = 180000;

    typedef struct {
        string          tag;
        logic [W-1:0]   a;
        logic [W-1:0]   b;
        logic [W-1:0]   exp_sum;
        logic           exp_c;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] dec_sum;
    logic         dec_cout;

    int     checks   = 0;
    int     failures = 0;
    int     cycles   = 0;
    bit     done     = 1'b0;
    item_t  sb[$];

    always #10 clk = ~clk;   // 50 MHz

    bcd_csel_adder #(.DIGITS(DIGITS)) uut (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .dec_sum  (dec_sum),
        .dec_cout (dec_cout)
    );

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r = '0;
        int x = v;
        for (int k = 0; k < DIGITS; k++) begin
            r[4*k +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    // Driver: apply operands and push the expected result
    task automatic drive(input string tag, input int x, input int y);
        item_t it;
        it.tag     = tag;
        it.a       = to_bcd(x);
        it.b       = to_bcd(y);
        it.exp_sum = to_bcd((x + y) % 1000);
        it.exp_c   = (x + y) >= 1000;
        opnd_a = it.a;
        opnd_b = it.b;
        sb.push_back(it);
        #2;
    endtask

    // Monitor: settle, pop, compare
    initial begin
        forever begin
            item_t it;
            wait (sb.size() > 0);
            #1;
            it = sb.pop_front();
            checks++;
            if (dec_sum !== it.exp_sum) begin
                failures++;
                $display("FAIL %s sum a=%h b=%h actual=%h expected=%h",
                         it.tag, it.a, it.b, dec_sum, it.exp_sum);
            end
            checks++;
            if (dec_cout !== it.exp_c) begin
                failures++;
                $display("FAIL %s carry a=%h b=%h actual=%b expected=%b",
                         it.tag, it.a, it.b, dec_cout, it.exp_c);
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive("R1_zero", 0, 0);          // idle state: 000 + 000
        drive("R3", 568, 379);
        drive("R4", 123, 456);
        drive("R5", 9, 9);
        drive("R6", 5, 5);
        drive("R6_mid", 50, 50);
        drive("R7", 999, 1);
        drive("R7_chain", 499, 501);
        drive("R7_inc_to_skip", 95, 5);  // increment 9 -> 10 then adjust
        drive("R7_inc_wrap", 75, 85);    // 7+8=15 raw, plus increment
        drive("R8", 999, 999);
        drive("R2_edge", 500, 499);
        drive("R2_edge_hi", 500, 500);
        for (int i = 0; i < 1000; i++)
            for (int j = 0; j < 1000; j++)
                drive("R1_R2_sweep", i, j);
        wait (sb.size() == 0);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule